// File: doc/BRIEF.md
# Three-Phase Unidirectional Leg Hysteresis Gate Controller

This block produces the on/off commands for the two active switches in each leg of a three-phase, three-level, unidirectional rectifier. For every phase it subtracts the measured line current from the current command, passes the result through a hysteresis comparator with a programmable half-band, and holds the comparator decision in a per-phase state bit. The polarity of the phase voltage then chooses which switch the state bit drives. In the positive half cycle only the positive-half switch is modulated. It is turned on to put the leg at the zero level, which makes the current rise. In the negative half cycle only the negative-half switch is modulated. When both switches are off, the leg sits at the half-bus level that matches the polarity, and that level pulls the current magnitude back toward the command.

A programmable minimum dwell keeps the comparator state from changing again too soon after it has changed. This prevents chatter while the error hovers near a threshold. An enable input forces every gate low while the comparators keep tracking. Currents are signed fixed-point values. At a scale of 1/64 A per LSB, the nominal half-band of 0.5 A is a band setting of 32.

Top module: `leg_hyst_gate`

## Requirements
- R1: For each phase the error is the command minus the measurement, formed as signed two's complement with one extra bit, so extreme inputs never wrap.
- R2: The state bit of a phase becomes 1 at a clock edge where error > band (strict), provided the dwell rule allows a change.
- R3: The state bit becomes 0 at a clock edge where error < −band (strict), provided the dwell rule allows a change.
- R4: While −band ≤ error ≤ band, the state bit keeps its value.
- R5: Bit p of gate_pos_o is registered. It is 1 in the cycle after an edge exactly when, at that edge, en_i = 1, vpos_i[p] = 1 and the state bit of phase p after that edge is 1.
- R6: Bit p of gate_neg_o is registered. It is 1 in the cycle after an edge exactly when, at that edge, en_i = 1, vpos_i[p] = 0 and the state bit of phase p after that edge is 0.
- R7: gate_pos_o[p] and gate_neg_o[p] are never 1 at the same time.
- R8: With en_i = 0 at an edge, all six gates are 0 after it. The state bits keep following R2 to R4, so the gates reflect the tracked state as soon as enable returns.
- R9: After a state change, the next change of the same phase can occur no sooner than max(dwell_i, 1) edges later. Edges where the threshold condition holds before that point leave the state unchanged.
- R10: The synchronous reset rst_i = 1 clears every state bit and every gate to 0. The first change after reset is not delayed by the dwell.
- R11: The three phases are independent: each uses only its own command, measurement and polarity. Phase p uses bits [p*16 +: 16] of the current buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Gate enable; 0 forces all gates off |
| band_i | input | 16 | Hysteresis half-band, unsigned |
| dwell_i | input | 8 | Minimum edges between state changes |
| iref_i | input | 48 | Per-phase signed current commands, phase p at [p*16 +: 16] |
| imeas_i | input | 48 | Per-phase signed measured currents, same layout |
| vpos_i | input | 3 | Per-phase voltage polarity, 1 = positive |
| gate_pos_o | output | 3 | Positive-half switch commands |
| gate_neg_o | output | 3 | Negative-half switch commands |

## Verification
Every gate is due one edge after the inputs that decide it. A state change blocked by the dwell turns up only in later gate values, which the edge-by-edge comparison catches. The bench changes inputs 1 ns after a rising edge and keeps them steady through the next edge. One nanosecond after that edge, it advances its behavioural model with the inputs that were present at the edge and compares all six gates. For this reason no check samples a gate in the same cycle as the stimulus that changes it.

// File: rtl/leg_hyst_pkg.sv
package leg_hyst_pkg;
   typedef enum logic [1:0] {
      REQ_HOLD = 2'd0,
      REQ_SET  = 2'd1,
      REQ_CLR  = 2'd2
   } hyst_req_t;
endpackage

// File: rtl/leg_hyst_cmp.sv
module leg_hyst_cmp
   import leg_hyst_pkg::*;
#(
   parameter int IW = 16
) (
   input  logic signed [IW-1:0] ref_i,
   input  logic signed [IW-1:0] meas_i,
   input  logic        [IW-1:0] band_i,
   output hyst_req_t            req_o
);
   localparam int EW = IW + 1;

   logic signed [EW-1:0] err_s;
   logic signed [EW-1:0] band_s;
   logic signed [EW-1:0] nband_s;

   always_comb begin
      err_s   = {ref_i[IW-1], ref_i} - {meas_i[IW-1], meas_i};
      band_s  = {1'b0, band_i};
      nband_s = -band_s;
      if (err_s > band_s)       req_o = REQ_SET;
      else if (err_s < nband_s) req_o = REQ_CLR;
      else                      req_o = REQ_HOLD;
   end
endmodule

// File: rtl/leg_hyst_dwell.sv
module leg_hyst_dwell
   import leg_hyst_pkg::*;
#(
   parameter int MINW     = 8,
   parameter bit DWELL_EN = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  hyst_req_t       req_i,
   input  logic [MINW-1:0] dwell_i,
   output logic            state_d_o
);
   localparam logic [MINW-1:0] CNT_MAX = {MINW{1'b1}};
   localparam logic [MINW-1:0] CNT_ONE = MINW'(1);

   logic state_q;
   logic want;

   always_comb begin
      unique case (req_i)
         REQ_SET: want = 1'b1;
         REQ_CLR: want = 1'b0;
         default: want = state_q;
      endcase
   end

   generate
      if (DWELL_EN) begin : g_dwell
         logic [MINW-1:0] cnt_q;
         logic            allow;

         assign allow     = (cnt_q >= dwell_i);
         assign state_d_o = (allow && (want != state_q)) ? want : state_q;

         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               cnt_q <= CNT_MAX;
            end else if (state_d_o != state_q) begin
               cnt_q <= CNT_ONE;
            end else if (cnt_q != CNT_MAX) begin
               cnt_q <= cnt_q + CNT_ONE;
            end
         end
      end else begin : g_free
         logic unused_dwell;
         assign unused_dwell = ^dwell_i;
         assign state_d_o    = want;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= 1'b0;
      else       state_q <= state_d_o;
   end
endmodule

// File: rtl/leg_hyst_gate_map.sv
module leg_hyst_gate_map (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic vpos_i,
   input  logic state_d_i,
   output logic gate_pos_o,
   output logic gate_neg_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gate_pos_o <= 1'b0;
         gate_neg_o <= 1'b0;
      end else begin
         gate_pos_o <= en_i &  vpos_i &  state_d_i;
         gate_neg_o <= en_i & ~vpos_i & ~state_d_i;
      end
   end
endmodule

// File: rtl/leg_hyst_gate.sv
module leg_hyst_gate
   import leg_hyst_pkg::*;
#(
   parameter int PHASES   = 3,
   parameter int IW       = 16,
   parameter int MINW     = 8,
   parameter bit DWELL_EN = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 en_i,
   input  logic [IW-1:0]        band_i,
   input  logic [MINW-1:0]      dwell_i,
   input  logic [PHASES*IW-1:0] iref_i,
   input  logic [PHASES*IW-1:0] imeas_i,
   input  logic [PHASES-1:0]    vpos_i,
   output logic [PHASES-1:0]    gate_pos_o,
   output logic [PHASES-1:0]    gate_neg_o
);
   generate
      if (PHASES < 1) begin : g_bad_phases
         $error("leg_hyst_gate: PHASES must be at least 1");
      end
      if (IW < 2) begin : g_bad_iw
         $error("leg_hyst_gate: IW must be at least 2");
      end
      if (MINW < 2) begin : g_bad_minw
         $error("leg_hyst_gate: MINW must be at least 2");
      end
   endgenerate

   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_leg
         hyst_req_t req;
         logic      state_d;

         leg_hyst_cmp #(.IW(IW)) u_cmp (
            .ref_i  (iref_i[p*IW +: IW]),
            .meas_i (imeas_i[p*IW +: IW]),
            .band_i (band_i),
            .req_o  (req)
         );

         leg_hyst_dwell #(.MINW(MINW), .DWELL_EN(DWELL_EN)) u_dwell (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .req_i     (req),
            .dwell_i   (dwell_i),
            .state_d_o (state_d)
         );

         leg_hyst_gate_map u_map (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .en_i       (en_i),
            .vpos_i     (vpos_i[p]),
            .state_d_i  (state_d),
            .gate_pos_o (gate_pos_o[p]),
            .gate_neg_o (gate_neg_o[p])
         );
      end
   endgenerate
endmodule

// File: rtl/leg_hyst_gate_chk.sv
module leg_hyst_gate_chk #(
   parameter int PHASES = 3
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic [PHASES-1:0] vpos_i,
   input logic [PHASES-1:0] gate_pos_o,
   input logic [PHASES-1:0] gate_neg_o
);
   generate
      for (genvar p = 0; p < PHASES; p++) begin : g_chk
         // R7
         a_r7_leg_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
            !(gate_pos_o[p] && gate_neg_o[p]));
         // R5
         a_r5_pos_needs_positive: assert property (@(posedge clk_i) disable iff (rst_i)
            gate_pos_o[p] |-> ($past(vpos_i[p]) && $past(en_i)));
         // R6
         a_r6_neg_needs_negative: assert property (@(posedge clk_i) disable iff (rst_i)
            gate_neg_o[p] |-> (!$past(vpos_i[p]) && $past(en_i)));
         // R8
         a_r8_disable_forces_off: assert property (@(posedge clk_i) disable iff (rst_i)
            !$past(en_i) |-> (!gate_pos_o[p] && !gate_neg_o[p]));
         // R10
         a_r10_reset_clears_gates: assert property (@(posedge clk_i) disable iff (rst_i)
            $past(rst_i) |-> (!gate_pos_o[p] && !gate_neg_o[p]));
      end
   endgenerate
endmodule

bind leg_hyst_gate leg_hyst_gate_chk #(.PHASES(PHASES)) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .en_i       (en_i),
   .vpos_i     (vpos_i),
   .gate_pos_o (gate_pos_o),
   .gate_neg_o (gate_neg_o)
);

// File: tb/leg_hyst_gate_test.sv
module leg_hyst_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int PH = 3;
   localparam int IW = 16;
   localparam int MW = 8;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic                 rst = 1'b1;
   logic                 en  = 1'b0;
   logic [IW-1:0]        band = '0;
   logic [MW-1:0]        dwell = '0;
   logic signed [IW-1:0] iref [PH];
   logic signed [IW-1:0] imeas [PH];
   logic [PH-1:0]        vpos = '0;
   logic [PH*IW-1:0]     iref_bus, imeas_bus;
   logic [PH-1:0]        gpos, gneg;

   always_comb begin
      for (int p = 0; p < PH; p++) begin
         iref_bus[p*IW +: IW]  = iref[p];
         imeas_bus[p*IW +: IW] = imeas[p];
      end
   end

   leg_hyst_gate uut (
      .clk_i(clk), .rst_i(rst), .en_i(en), .band_i(band), .dwell_i(dwell),
      .iref_i(iref_bus), .imeas_i(imeas_bus), .vpos_i(vpos),
      .gate_pos_o(gpos), .gate_neg_o(gneg)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int m_hs [PH];
   int m_held [PH];
   bit m_pos [PH];
   bit m_neg [PH];

   task automatic tick(input string tag);
      @(posedge clk);
      #1;
      for (int p = 0; p < PH; p++) begin
         if (rst) begin
            m_hs[p] = 0; m_held[p] = 1 << 30; m_pos[p] = 0; m_neg[p] = 0;
         end else begin
            int e, b, want;
            e = int'(iref[p]) - int'(imeas[p]);
            b = int'(band);
            want = (e > b) ? 1 : ((e < -b) ? 0 : m_hs[p]);
            if (want != m_hs[p] && m_held[p] >= int'(dwell)) begin
               m_hs[p] = want; m_held[p] = 1;
            end else if (m_held[p] < (1 << 30)) begin
               m_held[p]++;
            end
            m_pos[p] = en && vpos[p] && (m_hs[p] == 1);
            m_neg[p] = en && !vpos[p] && (m_hs[p] == 0);
         end
         checks++;
         if (gpos[p] !== m_pos[p] || gneg[p] !== m_neg[p]) begin
            failures++;
            $display("FAIL %s phase %0d: pos=%b neg=%b expected pos=%b neg=%b",
                     tag, p, gpos[p], gneg[p], m_pos[p], m_neg[p]);
         end
         checks++;
         if (gpos[p] === 1'b1 && gneg[p] === 1'b1) begin
            failures++;
            $display("FAIL R7 phase %0d: pos=%b neg=%b expected not both 1", p, gpos[p], gneg[p]);
         end
      end
   endtask

   task automatic set_all(input int r, input int m);
      for (int p = 0; p < PH; p++) begin
         iref[p] = IW'(r); imeas[p] = IW'(m);
      end
   endtask

   task automatic summary;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int seed;
      set_all(0, 0);
      for (int i = 0; i < 3; i++) tick("R10 reset state");
      rst = 1'b0; en = 1'b1; band = 16'd32; dwell = 8'd0; vpos = 3'b111;
      tick("R4 zero error holds 0");
      set_all(0, -40);
      tick("R2 error above band sets, R5 positive gate");
      tick("R5 positive gate holds");
      set_all(0, 32);
      tick("R4 error at -band holds");
      set_all(32, 0);
      tick("R4 error at +band holds");
      set_all(0, 33);
      tick("R3 error below -band clears");
      vpos = 3'b000;
      tick("R6 negative gate with state 0");
      set_all(33, 0);
      tick("R2 set turns negative gate off, R6");
      en = 1'b0;
      set_all(0, 100);
      tick("R8 disabled, state clears in background");
      tick("R8 disabled gates off");
      en = 1'b1; set_all(0, 0);
      tick("R8 gates reflect tracked state");
      set_all(32767, -32768);
      tick("R1 extreme positive error no wrap");
      set_all(-32768, 32767);
      tick("R1 extreme negative error no wrap");
      dwell = 8'd5; vpos = 3'b101;
      for (int i = 0; i < 24; i++) begin
         if ((i % 2) == 0) set_all(100, 0); else set_all(-100, 0);
         tick("R9 dwell blocks fast toggling");
      end
      rst = 1'b1;
      tick("R10 mid-run reset");
      rst = 1'b0; set_all(100, 0);
      tick("R10 first change not delayed after reset");
      dwell = 8'd3; band = 16'd32;
      seed = 7;
      for (int i = 0; i < 400; i++) begin
         for (int p = 0; p < PH; p++) begin
            seed = seed * 1103515245 + 12345;
            iref[p]  = IW'(((seed >>> 16) & 255) - 128);
            seed = seed * 1103515245 + 12345;
            imeas[p] = IW'(((seed >>> 16) & 63) - 32);
         end
         seed = seed * 1103515245 + 12345;
         vpos = PH'((seed >>> 20) & 7);
         en = ((seed >>> 12) & 15) != 0;
         if ((i % 100) == 50) dwell = dwell + 8'd2;
         tick("R11 independent phases mixed");
      end
      done = 1;
      summary();
      $finish;
   end
endmodule